// File: doc/BRIEF.md
# Prioritised External Interrupt Controller

This block gathers a set of level-sensitive external interrupt lines, samples them into a pending array, masks them with a per-line enable array, and picks the line that should be serviced next. Each line carries a small priority value. The block raises one external-interrupt request towards a RISC-V style core. That request is gated by the core's global interrupt enable and its external interrupt enable. It is also held back while a line of equal or higher priority is already being serviced.

Software reaches the enable array and the pending array through 16-bit windows chosen by a small index. Window 0 covers lines 15..0 and window 1 covers lines 31..16. A read-only next-interrupt word gives the winning line number multiplied by four, so it can index a table of 32-bit vectors directly. This word is combinational and follows the pending state as it changes, so a handler should sample it once on entry. Trap entry and trap exit arrive as single-cycle pulses. Entry saves the level in service on a small stack and takes the winner's level. Exit restores the saved level.

There is no streaming data path. Every pin is a plain control or status signal, and no valid/ready handshake applies.

Top module: `xirq_ctrl`

## Requirements
- R1: The pending array is the input level registered once. A line raised or dropped before a clock edge shows up or disappears in `pend_rdata` after that edge. Window 0 returns lines 15..0 and window 1 returns lines 31..16.
- R2: A pulse on `en_we` with `win_idx` 0 writes `win_wdata` to the enables of lines 15..0. With `win_idx` 1 it writes lines 31..16. `en_rdata` reads back the selected window, and the other window is left unchanged.
- R3: A `win_idx` of 2 or 3 reads zero on both `en_rdata` and `pend_rdata`, and any enable write made there changes no enable bit.
- R4: `next_valid` is 1 exactly when some line is both pending and enabled. `next_word` then equals four times the winning line number (line k gives 4*k), and it reads zero when `next_valid` is 0.
- R5: The winner is the pending, enabled line with the highest priority value. Among lines with equal priority, the lowest-numbered line wins.
- R6: `ext_req` can be 1 only while both `core_gie` (status bit 3) and `core_xie` (enable bit 11) are 1.
- R7: A `trap_enter` pulse taken while `ext_req` is 1 sets the level in service to the winner's priority. From then on, `ext_req` stays 0 unless some pending, enabled line has a strictly higher priority.
- R8: A `trap_exit` pulse restores the level in service that was in force before the matching entry. After the outermost exit, any pending, enabled line may request again.
- R9: `req_cause` reads 0x8000000B (interrupt flag plus cause code 11) while `ext_req` is 1, and reads zero otherwise.
- R10: After reset, all enables and priorities are 0, no level is in service, and `ext_req`, `next_valid`, `next_word` and `req_cause` are 0.
- R11: The next-interrupt word ignores the level in service. While a line is being serviced and is still pending, `next_word` keeps reporting it even though `ext_req` is 0.
- R12: A pulse on `prio_we` sets the 4-bit priority of line `prio_sel` to `prio_wdata`, and no other line's priority changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level-sensitive external interrupt lines |
| core_gie | input | 1 | Core global machine interrupt enable |
| core_xie | input | 1 | Core external interrupt enable |
| win_idx | input | 2 | Window select for enable and pending access |
| en_we | input | 1 | Enable-window write strobe |
| win_wdata | input | 16 | Enable-window write data |
| en_rdata | output | 16 | Enable-window read data |
| pend_rdata | output | 16 | Pending-window read data |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | 5 | Line whose priority is written |
| prio_wdata | input | 4 | Priority value |
| trap_enter | input | 1 | Core took the external interrupt trap |
| trap_exit | input | 1 | Core returned from the trap |
| ext_req | output | 1 | External interrupt request to the core |
| req_cause | output | 32 | Trap cause for the pending request |
| next_valid | output | 1 | Some line is pending and enabled |
| next_word | output | 7 | Winning line number times four |

## Verification
The selector is first driven with a table of pending/enable patterns: all lines raised, only the top line, a partly enabled upper window with sparse pending bits, and a pending line whose enable is clear. Between them these patterns separate a scan from the wrong end, a window mapping error, and a failure to mask. All 32 lines are then raised and dropped one at a time. The word must step 0, 4, ... 124, which exposes any bit of the index that is wrong. Unequal priorities are then combined with nested trap pulses. These runs show the difference between equal-priority masking, higher-priority preemption and the restore on exit, while the next-interrupt word stays blind to the level in service.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam logic [31:0] CAUSE_EXT = 32'h8000_000B;

  function automatic int clog2c(input int v);
    int r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs #(
  parameter int NLINES = 32,
  parameter int WIN    = 16,
  parameter int IDX_W  = 2,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDX_W-1:0]         win_idx,
  input  logic                     en_we,
  input  logic [WIN-1:0]           win_wdata,
  input  logic                     prio_we,
  input  logic [SEL_W-1:0]         prio_sel,
  input  logic [PRIO_W-1:0]        prio_wdata,
  output logic [NLINES-1:0]        en_vec,
  output logic [NLINES*PRIO_W-1:0] prio_flat
);
  localparam int NWIN = NLINES / WIN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_vec <= '0;
    end else if (en_we) begin
      for (int w = 0; w < NWIN; w++) begin
        if (win_idx == IDX_W'(w)) en_vec[w*WIN +: WIN] <= win_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_flat <= '0;
    end else if (prio_we) begin
      for (int i = 0; i < NLINES; i++) begin
        if (prio_sel == SEL_W'(i)) prio_flat[i*PRIO_W +: PRIO_W] <= prio_wdata;
      end
    end
  end
endmodule

// File: rtl/xirq_win_mux.sv
module xirq_win_mux #(
  parameter int NLINES = 32,
  parameter int WIN    = 16,
  parameter int IDX_W  = 2
) (
  input  logic [NLINES-1:0] vec,
  input  logic [IDX_W-1:0]  win_idx,
  output logic [WIN-1:0]    rdata
);
  localparam int NWIN = NLINES / WIN;

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NWIN; w++) begin
      if (win_idx == IDX_W'(w)) rdata = vec[w*WIN +: WIN];
    end
  end
endmodule

// File: rtl/xirq_pick.sv
module xirq_pick #(
  parameter int NLINES = 32,
  parameter int PRIO_W = 4,
  parameter int SEL_W  = 5
) (
  input  logic [NLINES-1:0]        cand,
  input  logic [NLINES*PRIO_W-1:0] prio_flat,
  output logic                     found,
  output logic [SEL_W-1:0]         best_idx,
  output logic [PRIO_W-1:0]        best_prio
);
  logic [PRIO_W-1:0] prio_arr [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_unpack
    assign prio_arr[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  // Scan from the top line downwards; ">=" lets a lower line win a tie.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio_arr[i] >= best_prio)) begin
        found     = 1'b1;
        best_idx  = SEL_W'(i);
        best_prio = prio_arr[i];
      end
    end
  end
endmodule

// File: rtl/xirq_lvl_stack.sv
module xirq_lvl_stack #(
  parameter int LVL_W = 5,
  parameter int DEPTH = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [LVL_W-1:0] new_lvl,
  output logic [LVL_W-1:0] cur_lvl
);
  localparam int SP_W = xirq_pkg::clog2c(DEPTH + 1);

  logic [LVL_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]  sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_lvl <= '0;
      sp      <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (sp == SP_W'(i)) stk[i] <= cur_lvl;
      end
      if (sp < SP_W'(DEPTH)) sp <= sp + SP_W'(1);
      cur_lvl <= new_lvl;
    end else if (pop) begin
      if (sp != '0) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (sp == SP_W'(i + 1)) cur_lvl <= stk[i];
        end
        sp <= sp - SP_W'(1);
      end else begin
        cur_lvl <= '0;
      end
    end
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int NLINES = 32,
  parameter int WIN    = 16,
  parameter int IDX_W  = 2,
  parameter int PRIO_W = 4,
  localparam int SEL_W  = xirq_pkg::clog2c(NLINES),
  localparam int NXT_W  = SEL_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_lines,
  input  logic              core_gie,
  input  logic              core_xie,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic              en_we,
  input  logic [WIN-1:0]    win_wdata,
  output logic [WIN-1:0]    en_rdata,
  output logic [WIN-1:0]    pend_rdata,
  input  logic              prio_we,
  input  logic [SEL_W-1:0]  prio_sel,
  input  logic [PRIO_W-1:0] prio_wdata,
  input  logic              trap_enter,
  input  logic              trap_exit,
  output logic              ext_req,
  output logic [31:0]       req_cause,
  output logic              next_valid,
  output logic [NXT_W-1:0]  next_word
);
  localparam int LVL_W = PRIO_W + 1;
  localparam int DEPTH = (1 << PRIO_W) + 1;

  logic [NLINES-1:0]        pend_q;
  logic [NLINES-1:0]        en_vec;
  logic [NLINES*PRIO_W-1:0] prio_flat;
  logic                     found;
  logic [SEL_W-1:0]         best_idx;
  logic [PRIO_W-1:0]        best_prio;
  logic [LVL_W-1:0]         cur_lvl;
  logic [LVL_W-1:0]         win_lvl;
  logic [LVL_W-1:0]         push_lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_lines;
  end

  xirq_cfg_regs #(.NLINES(NLINES), .WIN(WIN), .IDX_W(IDX_W), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .win_idx(win_idx), .en_we(en_we), .win_wdata(win_wdata),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .en_vec(en_vec), .prio_flat(prio_flat)
  );

  xirq_win_mux #(.NLINES(NLINES), .WIN(WIN), .IDX_W(IDX_W)) u_en_rd (
    .vec(en_vec), .win_idx(win_idx), .rdata(en_rdata)
  );

  xirq_win_mux #(.NLINES(NLINES), .WIN(WIN), .IDX_W(IDX_W)) u_pend_rd (
    .vec(pend_q), .win_idx(win_idx), .rdata(pend_rdata)
  );

  xirq_pick #(.NLINES(NLINES), .PRIO_W(PRIO_W), .SEL_W(SEL_W)) u_pick (
    .cand(pend_q & en_vec), .prio_flat(prio_flat),
    .found(found), .best_idx(best_idx), .best_prio(best_prio)
  );

  // Level encoding: 0 = nothing in service, p+1 = priority p in service.
  assign win_lvl  = {1'b0, best_prio} + LVL_W'(1);
  assign ext_req  = core_gie & core_xie & found & (win_lvl > cur_lvl);
  assign push_lvl = ext_req ? win_lvl : cur_lvl;

  xirq_lvl_stack #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(trap_enter), .pop(trap_exit),
    .new_lvl(push_lvl), .cur_lvl(cur_lvl)
  );

  assign next_valid = found;
  assign next_word  = found ? {best_idx, 2'b00} : '0;
  assign req_cause  = ext_req ? xirq_pkg::CAUSE_EXT : 32'h0;
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int NLINES = 32,
  parameter int WIN    = 16,
  parameter int IDX_W  = 2,
  parameter int NXT_W  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] irq_lines,
  input logic              core_gie,
  input logic              core_xie,
  input logic [IDX_W-1:0]  win_idx,
  input logic [WIN-1:0]    en_rdata,
  input logic [WIN-1:0]    pend_rdata,
  input logic              ext_req,
  input logic [31:0]       req_cause,
  input logic              next_valid,
  input logic [NXT_W-1:0]  next_word
);
  localparam int NWIN = NLINES / WIN;

  AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (core_gie && core_xie)); // R6

  AST_REQ_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> next_valid); // R7

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    next_word[1:0] == 2'b00); // R4

  AST_WORD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !next_valid |-> (next_word == '0)); // R4

  AST_WIN_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(win_idx) >= NWIN) |-> (en_rdata == '0 && pend_rdata == '0)); // R3

  AST_PEND_TRACKS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && win_idx == '0) |-> (pend_rdata == $past(irq_lines[WIN-1:0]))); // R1

  AST_CAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_req |-> (req_cause == 32'h0)); // R9
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.NLINES(NLINES), .WIN(WIN), .IDX_W(IDX_W), .NXT_W(NXT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .core_gie(core_gie), .core_xie(core_xie),
  .win_idx(win_idx), .en_rdata(en_rdata), .pend_rdata(pend_rdata), .ext_req(ext_req),
  .req_cause(req_cause), .next_valid(next_valid), .next_word(next_word)
);

// File: tb/xirq_ctrl_tb.sv
module xirq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        core_gie = 1'b0, core_xie = 1'b0;
  logic [1:0]  win_idx = '0;
  logic        en_we = 1'b0;
  logic [15:0] win_wdata = '0;
  logic [15:0] en_rdata, pend_rdata;
  logic        prio_we = 1'b0;
  logic [4:0]  prio_sel = '0;
  logic [3:0]  prio_wdata = '0;
  logic        trap_enter = 1'b0, trap_exit = 1'b0;
  logic        ext_req, next_valid;
  logic [31:0] req_cause;
  logic [6:0]  next_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  xirq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .core_gie(core_gie), .core_xie(core_xie),
    .win_idx(win_idx), .en_we(en_we), .win_wdata(win_wdata), .en_rdata(en_rdata),
    .pend_rdata(pend_rdata), .prio_we(prio_we), .prio_sel(prio_sel), .prio_wdata(prio_wdata),
    .trap_enter(trap_enter), .trap_exit(trap_exit), .ext_req(ext_req), .req_cause(req_cause),
    .next_valid(next_valid), .next_word(next_word)
  );

  // {irq_lines, enables 15..0, enables 31..16, expected next_word, expected next_valid}
  localparam int VW = 32 + 16 + 16 + 7 + 1;
  localparam logic [VW-1:0] VEC [6] = '{
    {32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF, 7'd0,   1'b1},
    {32'hFFFF_FFFE, 16'hFFFF, 16'hFFFF, 7'd4,   1'b1},
    {32'h8000_0000, 16'hFFFF, 16'hFFFF, 7'd124, 1'b1},
    {32'hF0F0_0000, 16'hFFFF, 16'h00FF, 7'd80,  1'b1},
    {32'h0001_0000, 16'hFFFF, 16'h0000, 7'd0,   1'b0},
    {32'h0000_0000, 16'hFFFF, 16'hFFFF, 7'd0,   1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [1:0] idx, input logic [15:0] d);
    win_idx = idx; win_wdata = d; en_we = 1'b1;
    step();
    en_we = 1'b0;
  endtask

  task automatic wr_prio(input int line, input logic [3:0] p);
    prio_sel = 5'(line); prio_wdata = p; prio_we = 1'b1;
    step();
    prio_we = 1'b0;
  endtask

  task automatic pulse_enter();
    trap_enter = 1'b1; step(); trap_enter = 1'b0;
  endtask

  task automatic pulse_exit();
    trap_exit = 1'b1; step(); trap_exit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R10 reset state
    chk("R10 ext_req", 32'(ext_req), 0);
    chk("R10 next_valid", 32'(next_valid), 0);
    chk("R10 next_word", 32'(next_word), 0);
    chk("R10 req_cause", req_cause, 0);
    win_idx = 2'd0; step(); chk("R10 en win0", 32'(en_rdata), 0);
    win_idx = 2'd1; step(); chk("R10 en win1", 32'(en_rdata), 0);

    core_gie = 1'b1; core_xie = 1'b1;

    // Table-driven selection (R4, R5, R2)
    for (int v = 0; v < 6; v++) begin
      wr_en(2'd0, VEC[v][39:24]);
      wr_en(2'd1, VEC[v][23:8]);
      irq_lines = VEC[v][71:40];
      step();
      chk("R4 table next_word", 32'(next_word), 32'(VEC[v][7:1]));
      chk("R4 table next_valid", 32'(next_valid), 32'(VEC[v][0]));
      chk("R9 table cause", req_cause, VEC[v][0] ? 32'h8000_000B : 32'h0);
    end

    // R2 window write mapping
    wr_en(2'd0, 16'h1234);
    wr_en(2'd1, 16'hA5A5);
    win_idx = 2'd0; step(); chk("R2 win0 readback", 32'(en_rdata), 32'h1234);
    win_idx = 2'd1; step(); chk("R2 win1 readback", 32'(en_rdata), 32'hA5A5);

    // R3 out-of-range window
    wr_en(2'd2, 16'hFFFF);
    wr_en(2'd3, 16'h0F0F);
    win_idx = 2'd2; step(); chk("R3 en idx2 zero", 32'(en_rdata), 0);
    win_idx = 2'd0; step(); chk("R3 win0 kept", 32'(en_rdata), 32'h1234);
    win_idx = 2'd1; step(); chk("R3 win1 kept", 32'(en_rdata), 32'hA5A5);

    // R1 pending follows lines, window mapping
    irq_lines = 32'hDEAD_BEEF;
    win_idx = 2'd0; step(); chk("R1 pend win0", 32'(pend_rdata), 32'hBEEF);
    win_idx = 2'd1; step(); chk("R1 pend win1", 32'(pend_rdata), 32'hDEAD);
    win_idx = 2'd3; step(); chk("R3 pend idx3 zero", 32'(pend_rdata), 0);
    irq_lines = 32'h0000_0000;
    win_idx = 2'd0; step(); chk("R1 pend cleared", 32'(pend_rdata), 0);

    // Drain: all lines raised, dropped lowest first (R4, R5)
    wr_en(2'd0, 16'hFFFF);
    wr_en(2'd1, 16'hFFFF);
    irq_lines = 32'hFFFF_FFFF;
    step();
    for (int k = 0; k < 32; k++) begin
      chk("R5 drain next_word", 32'(next_word), 32'(4 * k));
      irq_lines[k] = 1'b0;
      step();
    end
    chk("R4 drain empty", 32'(next_valid), 0);

    // R6 gating
    irq_lines = 32'h0000_0100;
    step();
    chk("R6 both enables", 32'(ext_req), 1);
    core_gie = 1'b0; step(); chk("R6 gie low", 32'(ext_req), 0);
    core_gie = 1'b1; core_xie = 1'b0; step(); chk("R6 xie low", 32'(ext_req), 0);
    core_xie = 1'b1; step();

    // R7 / R11 no self preemption at equal priority
    irq_lines = 32'hFFFF_FFFF;
    step();
    pulse_enter();
    chk("R7 same prio masked", 32'(ext_req), 0);
    chk("R11 next still line0", 32'(next_word), 0);
    chk("R11 next valid", 32'(next_valid), 1);
    pulse_exit();
    chk("R8 restored request", 32'(ext_req), 1);

    // R12 / R5 priorities, R7 preempt, R8 nesting
    wr_prio(9, 4'd3);
    chk("R12 line9 wins", 32'(next_word), 36);
    pulse_enter();
    chk("R7 prio3 in service", 32'(ext_req), 0);
    wr_prio(5, 4'd7);
    chk("R12 line5 wins", 32'(next_word), 20);
    chk("R7 higher preempts", 32'(ext_req), 1);
    pulse_enter();
    chk("R7 prio7 in service", 32'(ext_req), 0);
    pulse_exit();
    chk("R8 back to prio3", 32'(ext_req), 1);
    wr_prio(5, 4'd3);
    chk("R5 tie lowest line", 32'(next_word), 20);
    chk("R7 equal not preempt", 32'(ext_req), 0);
    pulse_exit();
    chk("R8 outermost exit", 32'(ext_req), 1);
    chk("R9 cause on request", req_cause, 32'h8000_000B);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule